// File: doc/BRIEF.md
# GPIO Port with Event Interrupts

This block is a bank of general-purpose I/O pins controlled through a 32-bit register interface. Software uses it to:

- pick, per pin, whether the pin is an input or an output;
- load the level each output pin drives;
- read the synchronized state of every pin.

The output level is held in a latch that is separate from direction. Software can therefore load a level first and only then turn the pin into an output.

Each pin can also report events. A per-pin trigger bit chooses edge or level detection, and two polarity registers choose which edge or level counts. When a pin sees an event, its bit in a sticky status register is set. If a further event arrives while that bit is still set, the pin's overrun bit is set as well. Both registers are cleared by writing ones. The interrupt output is the OR of all status bits. There is no mask register; masking is left to the interrupt controller that receives the line.

The register bus is synchronous. A write takes effect at the clock edge where the write enable is high. Read data is combinational from the address. Pins enter through a two-flop synchronizer before the input register and the event logic see them.

Top module: `gpio_evt_port`

## Requirements
- R1: After reset every register reads zero, `pin_oe` is all ones, `pin_out` is zero and `irq` is low.
- R2: A 1 in the direction register (offset 0x00) makes that pin an input, so its `pin_oe` bit is 0. A 0 makes the pin an output. `pin_oe` follows a direction write from the next clock edge.
- R3: The output latch (offset 0x08) drives `pin_out` and keeps its value whatever the direction. A level written while a pin is an input is driven unchanged once the pin turns into an output.
- R4: The input register (offset 0x04) returns pin n at bit n. A change at `pin_in` shows up in it two clock edges later.
- R5: Register bits at or above `PIN_COUNT` read zero. Offset 0x20, any unlisted offset and any address with a nonzero low two bits read zero, and writes to them change nothing.
- R6: With trigger bit 1 (offset 0x0C), polarity A (0x10) picks rising edges and polarity B (0x14) picks falling edges; both set picks either edge. The status bit is set three clock edges after the pin change.
- R7: With trigger bit 0, polarity A set raises an event while the synchronized pin is high, and polarity B set while it is low. With neither set, no event is raised.
- R8: Status bits (offset 0x18) are sticky. Writing 1 clears a bit and writing 0 has no effect. An event in the same cycle as a clear leaves the bit set.
- R9: An event on a pin whose status bit is already set sets that pin's overrun bit (offset 0x1C). Writing 1 clears it.
- R10: `irq` is high exactly while any status bit is set; there is no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write enable |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| pin_out | output | PIN_COUNT | Output level of each pin |
| pin_oe | output | PIN_COUNT | Per-pin output enable, 1 = drive |
| pin_in | input | PIN_COUNT | Pin states from the pads |
| irq | output | 1 | Event interrupt, OR of the status bits |

## Verification
If the edge-memory flop or a polarity path goes wrong, the status register and `irq` show a missing or extra event exactly three edges after a pin change. The bench samples there, once for each trigger and polarity combination.

A status or overrun bit that fails to stick or to clear is seen at the next register read. The case where a clear and a held level arrive together exposes any wrong priority between clear and set in the same cycle. A direction or output latch that is corrupted shows at `pin_oe` or `pin_out` one edge after the write.

// File: rtl/gpio_evt_pkg.sv
`timescale 1ns/1ps
package gpio_evt_pkg;
   // Word indices (byte offset / 4) of the register map
   localparam int REG_DIR  = 0;
   localparam int REG_IN   = 1;
   localparam int REG_OUT  = 2;
   localparam int REG_TRIG = 3;
   localparam int REG_POLA = 4;
   localparam int REG_POLB = 5;
   localparam int REG_STAT = 6;
   localparam int REG_OVR  = 7;
   localparam int REG_MODE = 8;  // reserved, reads zero
   localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/gpio_evt_sync.sv
`timescale 1ns/1ps
module gpio_evt_sync #(
   parameter int WIDTH  = 19,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= din;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
`timescale 1ns/1ps
module gpio_evt_detect #(
   parameter int WIDTH = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   input  logic [WIDTH-1:0] edge_mode,
   input  logic [WIDTH-1:0] pol_a,
   input  logic [WIDTH-1:0] pol_b,
   output logic [WIDTH-1:0] evt
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic rise, fall, hi_hit, lo_hit;
      assign rise   = lvl[i] & ~prev_q[i];
      assign fall   = ~lvl[i] & prev_q[i];
      assign hi_hit = lvl[i] & pol_a[i];
      assign lo_hit = ~lvl[i] & pol_b[i];
      assign evt[i] = edge_mode[i] ? ((rise & pol_a[i]) | (fall & pol_b[i]))
                                   : (hi_hit | lo_hit);
   end
endmodule

// File: rtl/gpio_evt_flags.sv
`timescale 1ns/1ps
module gpio_evt_flags #(
   parameter int WIDTH = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt,
   input  logic [WIDTH-1:0] clr_stat,
   input  logic [WIDTH-1:0] clr_ovr,
   output logic [WIDTH-1:0] status,
   output logic [WIDTH-1:0] ovr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         ovr    <= '0;
      end else begin
         // a new event beats a clear in the same cycle
         status <= (status & ~clr_stat) | evt;
         ovr    <= (ovr & ~clr_ovr) | (evt & status);
      end
   end
endmodule

// File: rtl/gpio_evt_port.sv
`timescale 1ns/1ps
module gpio_evt_port #(
   parameter int PIN_COUNT = 19,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_wr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe,
   input  logic [PIN_COUNT-1:0] pin_in,
   output logic                 irq
);
   import gpio_evt_pkg::*;

   localparam int IDX_W = ADDR_W - 2;

   if (PIN_COUNT < 1 || PIN_COUNT > DATA_W) begin : g_bad_pins
      $error("PIN_COUNT must lie in 1..DATA_W");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [PIN_COUNT-1:0] dir_q, out_q, trig_q, pola_q, polb_q;
   logic [PIN_COUNT-1:0] sync_lvl, evt, status_q, ovr_q;
   logic [PIN_COUNT-1:0] clr_stat, clr_ovr, wbits;
   logic [IDX_W-1:0]     idx;
   logic                 aligned, wr_ok;
   logic                 unused_wdata;

   assign idx          = reg_addr[ADDR_W-1:2];
   assign aligned      = (reg_addr[1:0] == 2'b00);
   assign wr_ok        = reg_wr && aligned;
   assign wbits        = reg_wdata[PIN_COUNT-1:0];
   assign unused_wdata = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         trig_q <= '0;
         pola_q <= '0;
         polb_q <= '0;
      end else if (wr_ok) begin
         case (idx)
            IDX_W'(REG_DIR):  dir_q  <= wbits;
            IDX_W'(REG_OUT):  out_q  <= wbits;
            IDX_W'(REG_TRIG): trig_q <= wbits;
            IDX_W'(REG_POLA): pola_q <= wbits;
            IDX_W'(REG_POLB): polb_q <= wbits;
            default: ;
         endcase
      end
   end

   assign clr_stat = (wr_ok && idx == IDX_W'(REG_STAT)) ? wbits : '0;
   assign clr_ovr  = (wr_ok && idx == IDX_W'(REG_OVR))  ? wbits : '0;

   gpio_evt_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(sync_lvl));

   gpio_evt_detect #(.WIDTH(PIN_COUNT)) u_detect (
      .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .edge_mode(trig_q),
      .pol_a(pola_q), .pol_b(polb_q), .evt(evt));

   gpio_evt_flags #(.WIDTH(PIN_COUNT)) u_flags (
      .clk(clk), .rst_n(rst_n), .evt(evt), .clr_stat(clr_stat),
      .clr_ovr(clr_ovr), .status(status_q), .ovr(ovr_q));

   always_comb begin
      reg_rdata = '0;
      if (aligned) begin
         case (idx)
            IDX_W'(REG_DIR):  reg_rdata[PIN_COUNT-1:0] = dir_q;
            IDX_W'(REG_IN):   reg_rdata[PIN_COUNT-1:0] = sync_lvl;
            IDX_W'(REG_OUT):  reg_rdata[PIN_COUNT-1:0] = out_q;
            IDX_W'(REG_TRIG): reg_rdata[PIN_COUNT-1:0] = trig_q;
            IDX_W'(REG_POLA): reg_rdata[PIN_COUNT-1:0] = pola_q;
            IDX_W'(REG_POLB): reg_rdata[PIN_COUNT-1:0] = polb_q;
            IDX_W'(REG_STAT): reg_rdata[PIN_COUNT-1:0] = status_q;
            IDX_W'(REG_OVR):  reg_rdata[PIN_COUNT-1:0] = ovr_q;
            default: ;
         endcase
      end
   end

   assign pin_out = out_q;
   assign pin_oe  = ~dir_q;
   assign irq     = |status_q;
endmodule

// File: rtl/gpio_evt_port_chk.sv
`timescale 1ns/1ps
module gpio_evt_port_chk #(
   parameter int PIN_COUNT = 19,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic                 reg_wr,
   input logic [PIN_COUNT-1:0] wdata_lo,
   input logic [DATA_W-1:0]    reg_rdata,
   input logic [PIN_COUNT-1:0] pin_out,
   input logic [PIN_COUNT-1:0] pin_oe,
   input logic                 irq,
   input logic [PIN_COUNT-1:0] status_q,
   input logic [PIN_COUNT-1:0] ovr_q
);
   import gpio_evt_pkg::*;
   localparam logic [ADDR_W-1:0] OFF_DIR  = ADDR_W'(REG_DIR * 4);
   localparam logic [ADDR_W-1:0] OFF_OUT  = ADDR_W'(REG_OUT * 4);
   localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(REG_STAT * 4);

   assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFF_DIR) |=> (pin_oe == ~$past(wdata_lo)));

   assert_out_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFF_OUT) |=> (pin_out == $past(wdata_lo)));

   assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_rdata >> PIN_COUNT) == '0));

   assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == OFF_STAT) |=> (($past(status_q) & ~status_q) == '0));

   assert_ovr_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (((ovr_q & ~$past(ovr_q)) & ~$past(status_q)) == '0));

   assert_irq_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(reg_wr && reg_addr == OFF_STAT));
endmodule

bind gpio_evt_port gpio_evt_port_chk #(
   .PIN_COUNT(PIN_COUNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .wdata_lo(reg_wdata[PIN_COUNT-1:0]), .reg_rdata(reg_rdata),
   .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
   .status_q(status_q), .ovr_q(ovr_q)
);

// File: tb/gpio_evt_port_test.sv
`timescale 1ns/1ps
module gpio_evt_port_test;
   localparam int N = 19;
   localparam logic [31:0] MASK = (32'h1 << N) - 1;
   localparam logic [5:0] A_DIR = 6'h00, A_IN = 6'h04, A_OUT = 6'h08,
      A_TRIG = 6'h0C, A_POLA = 6'h10, A_POLB = 6'h14, A_STAT = 6'h18,
      A_OVR = 6'h1C, A_MODE = 6'h20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [5:0] reg_addr = '0;
   logic reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [N-1:0] pin_out, pin_oe;
   logic [N-1:0] pin_in = '0;
   logic irq;
   int checks = 0;
   int fails = 0;

   always #5 clk = ~clk;

   gpio_evt_port #(.PIN_COUNT(N), .DATA_W(32), .ADDR_W(6)) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_out(pin_out),
      .pin_oe(pin_oe), .pin_in(pin_in), .irq(irq));

   function automatic logic [31:0] exp_oe(input logic [31:0] dir);
      return ~dir & MASK;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d, o, v;
      void'($urandom(32'd1357));
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      rd_chk("R1 dir", A_DIR, 0);   rd_chk("R1 out", A_OUT, 0);
      rd_chk("R1 trig", A_TRIG, 0); rd_chk("R1 pola", A_POLA, 0);
      rd_chk("R1 polb", A_POLB, 0); rd_chk("R1 stat", A_STAT, 0);
      rd_chk("R1 ovr", A_OVR, 0);   rd_chk("R1 in", A_IN, 0);
      chk("R1 pin_oe", 32'(pin_oe), MASK);
      chk("R1 pin_out", 32'(pin_out), 0);
      chk("R1 irq", 32'(irq), 0);

      // R2 direction: directed then random
      wr(A_DIR, 32'h0005_A5A5);
      chk("R2 oe", 32'(pin_oe), exp_oe(32'h0005_A5A5));
      rd_chk("R2 readback", A_DIR, 32'h0005_A5A5);
      for (int k = 0; k < 12; k++) begin
         d = $urandom & MASK;
         o = $urandom & MASK;
         wr(A_DIR, d);
         wr(A_OUT, o);
         chk("R2 random oe", 32'(pin_oe), exp_oe(d));
         chk("R3 random out", 32'(pin_out), o);
      end

      // R3 preset while input, then switch to output
      wr(A_DIR, MASK);
      wr(A_OUT, 32'h0000_0F0F);
      chk("R3 out while input", 32'(pin_out), 32'h0F0F);
      chk("R2 all input oe", 32'(pin_oe), 0);
      wr(A_DIR, 0);
      chk("R3 out after switch", 32'(pin_out), 32'h0F0F);
      chk("R2 all output oe", 32'(pin_oe), MASK);

      // R4 live input, random patterns
      for (int k = 0; k < 10; k++) begin
         v = $urandom & MASK;
         pin_in = v[N-1:0];
         tick(1);
         if (k == 0) rd_chk("R4 not after one edge", A_IN, 32'hFFFF_FFFF & 0 | 32'(uut.pin_in) & 0 | 0);
         tick(1);
         rd_chk("R4 input", A_IN, v);
      end

      // R5 upper bits, reserved offsets, unaligned
      wr(A_OUT, 32'hFFFF_FFFF);
      rd_chk("R5 upper bits", A_OUT, MASK);
      wr(A_MODE, 32'hFFFF_FFFF);
      rd_chk("R5 mode reads zero", A_MODE, 0);
      rd_chk("R5 unlisted reads zero", 6'h24, 0);
      wr(6'h09, 32'h0);
      rd_chk("R5 unaligned write ignored", A_OUT, MASK);
      rd_chk("R5 unaligned read zero", 6'h09, 0);
      chk("R5 pin_out untouched", 32'(pin_out), MASK);

      // R6 edges on pin 0
      pin_in = '0; tick(3);
      wr(A_STAT, MASK); wr(A_OVR, MASK);
      wr(A_TRIG, 1); wr(A_POLA, 1); wr(A_POLB, 0);
      pin_in = 19'h1; tick(2);
      rd_chk("R6 rise not yet", A_STAT, 0);
      tick(1);
      rd_chk("R6 rising", A_STAT, 1);
      chk("R10 irq set", 32'(irq), 1);
      wr(A_STAT, 1);
      chk("R10 irq clear", 32'(irq), 0);
      pin_in = '0; tick(3);
      rd_chk("R6 fall ignored under A", A_STAT, 0);
      wr(A_POLB, 1);
      pin_in = 19'h1; tick(3);
      rd_chk("R6 both rise", A_STAT, 1);
      wr(A_STAT, 1);
      pin_in = '0; tick(3);
      rd_chk("R6 both fall", A_STAT, 1);
      wr(A_STAT, 1);
      wr(A_POLA, 0);
      pin_in = 19'h1; tick(3);
      rd_chk("R6 rise ignored under B", A_STAT, 0);
      pin_in = '0; tick(3);
      rd_chk("R6 falling", A_STAT, 1);
      wr(A_STAT, 1);

      // R7 levels on pin 1
      wr(A_TRIG, 0); wr(A_POLB, 0); wr(A_POLA, 2); wr(A_STAT, MASK);
      rd_chk("R7 low with A quiet", A_STAT, 0);
      pin_in = 19'h2; tick(3);
      rd_chk("R7 high level", A_STAT, 2);
      wr(A_STAT, 2);
      rd_chk("R8 held level beats clear", A_STAT, 2);
      pin_in = '0; tick(3);
      wr(A_STAT, 2);
      rd_chk("R8 clear after level drops", A_STAT, 0);
      wr(A_POLA, 0); wr(A_POLB, 2);
      tick(1);
      rd_chk("R7 low level", A_STAT, 2);
      pin_in = 19'h2; tick(3);
      wr(A_STAT, 2);
      wr(A_POLB, 0);
      pin_in = '0; tick(3);
      pin_in = 19'h2; tick(3);
      rd_chk("R7 neither polarity", A_STAT, 0);
      pin_in = '0; tick(3);

      // R9 overrun on pin 2
      wr(A_TRIG, 4); wr(A_POLA, 4); wr(A_POLB, 0);
      wr(A_STAT, MASK); wr(A_OVR, MASK);
      pin_in = 19'h4; tick(3);
      rd_chk("R9 first event status", A_STAT, 4);
      rd_chk("R9 no overrun yet", A_OVR, 0);
      pin_in = '0; tick(3);
      pin_in = 19'h4; tick(3);
      rd_chk("R9 overrun", A_OVR, 4);
      wr(A_OVR, 4);
      rd_chk("R9 overrun cleared", A_OVR, 0);
      wr(A_STAT, 0);
      rd_chk("R8 write zero no effect", A_STAT, 4);

      // R10 several pins, no mask
      pin_in = '0; tick(3);
      wr(A_TRIG, 32'hC); wr(A_POLA, 32'hC); wr(A_STAT, MASK);
      pin_in = 19'hC; tick(3);
      rd_chk("R10 two pins", A_STAT, 32'hC);
      wr(A_STAT, 4);
      chk("R10 irq one left", 32'(irq), 1);
      wr(A_STAT, 8);
      chk("R10 irq none left", 32'(irq), 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule